// File: doc/BRIEF.md
# Software SMI Generator with Block Timer

This block lets firmware request a system management interrupt by writing a trigger register. A request goes through only when management interrupts are enabled, the software source is selected, and no earlier request is still blocking. Each request that goes through is delivered in one of two ways. The first is a level on a dedicated SMI line, which stays up until the processor acknowledges it. The second is a single-cycle pulse on one of four interrupt request outputs. A status bit records every request that goes through, and software clears it by writing one to it.

After a request goes through, a block flag suppresses further requests. A programmable down-counter removes the block. It counts in steps of 35 microseconds, derived from the system clock by a prescaler. The block is lifted when the count reaches one, so a loaded value N gives N-1 steps of blocking. Software can also reload the counter or restart the step sequence. A value below two never starts the counter.

Top module: `swsmi_gen`

## Requirements
- R1: A write to address 4 with bit 0 set raises a request only when bit 7 of address 0 (enable) is 1, bit 4 of address 2 (software source select) is 1, and `blocked_o` is 0. Otherwise it changes no output and no register.
- R2: When bit 4 of address 0 is 0, a request sets `smi_o` at the clock edge that samples the write. `smi_o` then stays 1 until a cycle with `smi_ack` high clears it.
- R3: When bit 4 of address 0 is 1, a request produces a single-cycle pulse on `irq_req` and leaves `smi_o` low. Bits 1:0 of address 1 select the output: 0 drives bit 0 (IRQ 10), 1 drives bit 1 (IRQ 11), 2 drives bit 2 (IRQ 12) and 3 drives bit 3 (IRQ 15).
- R4: A request sets `blocked_o` and sets bit 4 of status register 0 (address 5) at the same edge.
- R5: Status registers 0 and 1 (addresses 5 and 6) clear each bit written as one and keep each bit written as zero.
- R6: A write to address 3 loads the counter, which reads back at address 3. The write cancels any running countdown. The countdown starts again only if the value is 2 or more; bit 0 of address 4 reads 1 while it runs. Loading 0 or 1 leaves an active block in place.
- R7: A running countdown decrements once every `CLK_PER_US*STEP_US` clock cycles, counted from its start. When it reaches 1, the counter becomes 0, the countdown stops and `blocked_o` clears. A loaded value N ≥ 2 releases after N-1 steps.
- R8: A write to address 4 with bit 1 set restarts the step timing from zero without reloading the count, but only when the current count is 2 or more.
- R9: Address 1 keeps only the bits in mask 9Fh; the other bits read 0.
- R10: After reset, every readable register is 0 and `smi_o`, `irq_req` and `blocked_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| smi_ack | input | 1 | Processor acknowledge, clears `smi_o` |
| smi_o | output | 1 | Dedicated SMI line, held until acknowledged |
| irq_req | output | 4 | One-cycle IRQ request pulses (IRQ 10, 11, 12, 15) |
| blocked_o | output | 1 | Block flag suppressing new requests |

## Verification
A stuck or early block flag is visible at once: the next trigger write either fails to raise `smi_o` and status bit 4, or raises them when it should not. A counter that is off by one step, or a prescaler off by one cycle, moves the fall of `blocked_o` by exactly one step or one clock. The bench samples one clock either side of the predicted release edge, so both errors show up. A wrong IRQ select shows as the wrong `irq_req` bit in the cycle after the trigger write, and a pulse longer than one cycle shows one cycle later.

// File: rtl/swsmi_pkg.sv
package swsmi_pkg;
  localparam logic [2:0] A_PWRCFG = 3'd0;
  localparam logic [2:0] A_CPUTYP = 3'd1;
  localparam logic [2:0] A_SRCSEL = 3'd2;
  localparam logic [2:0] A_COUNT  = 3'd3;
  localparam logic [2:0] A_TRIG   = 3'd4;
  localparam logic [2:0] A_STAT0  = 3'd5;
  localparam logic [2:0] A_STAT1  = 3'd6;
  localparam logic [7:0] CPUTYP_KEEP = 8'h9F;

  // one-hot request line for the IRQ selector: 10, 11, 12, 15
  function automatic logic [3:0] f_irq_onehot(input logic [1:0] sel);
    return 4'b0001 << sel;
  endfunction

  // a count may only run when it can still step down to one
  function automatic logic f_can_run(input logic [7:0] cnt);
    return cnt >= 8'd2;
  endfunction

  // the step that lands on one releases the block
  function automatic logic f_step_releases(input logic [7:0] cnt);
    return cnt == 8'd2;
  endfunction
endpackage

// File: rtl/swsmi_prescaler.sv
module swsmi_prescaler #(
  parameter int TICK_DIV = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic step
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  assign step = en && !clr && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !en || step) pre_q <= '0;
    else                              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/swsmi_regs.sv
module swsmi_regs
  import swsmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       blocked,
  output logic       fire,
  output logic       restart,
  output logic       cnt_load,
  output logic       irq_mode,
  output logic [1:0] irq_sel,
  output logic [7:0] pwrcfg_q,
  output logic [7:0] cputyp_q,
  output logic [7:0] srcsel_q,
  output logic [7:0] stat0_q,
  output logic [7:0] stat1_q
);
  logic wr_trig;
  assign wr_trig  = cfg_we && (cfg_addr == A_TRIG);
  assign fire     = wr_trig && cfg_wdata[0] && !blocked && pwrcfg_q[7] && srcsel_q[4];
  assign restart  = wr_trig && cfg_wdata[1];
  assign cnt_load = cfg_we && (cfg_addr == A_COUNT);
  assign irq_mode = pwrcfg_q[4];
  assign irq_sel  = cputyp_q[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwrcfg_q <= '0;
      cputyp_q <= '0;
      srcsel_q <= '0;
      stat0_q  <= '0;
      stat1_q  <= '0;
    end else begin
      if (cfg_we) begin
        unique case (cfg_addr)
          A_PWRCFG: pwrcfg_q <= cfg_wdata;
          A_CPUTYP: cputyp_q <= cfg_wdata & CPUTYP_KEEP;
          A_SRCSEL: srcsel_q <= cfg_wdata;
          A_STAT0:  stat0_q  <= stat0_q & ~cfg_wdata;
          A_STAT1:  stat1_q  <= stat1_q & ~cfg_wdata;
          default:  ;
        endcase
      end
      if (fire) stat0_q[4] <= 1'b1;
    end
  end
endmodule

// File: rtl/swsmi_blocktimer.sv
module swsmi_blocktimer
  import swsmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       restart,
  input  logic       step,
  input  logic       fire,
  output logic [7:0] cnt_q,
  output logic       run_q,
  output logic       blocked_q,
  output logic       release_ev
);
  assign release_ev = step && !load && !restart && f_step_releases(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= f_can_run(load_val);
    end else if (restart) begin
      run_q <= f_can_run(cnt_q);
    end else if (step) begin
      if (release_ev) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          blocked_q <= 1'b0;
    else if (fire)       blocked_q <= 1'b1;
    else if (release_ev) blocked_q <= 1'b0;
  end
endmodule

// File: rtl/swsmi_gen.sv
module swsmi_gen
  import swsmi_pkg::*;
#(
  parameter int CLK_PER_US = 2,
  parameter int STEP_US    = 35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       smi_ack,
  output logic       smi_o,
  output logic [3:0] irq_req,
  output logic       blocked_o
);
  localparam int TICK_DIV = CLK_PER_US * STEP_US;

  logic       fire, restart, cnt_load, irq_mode, step, run_q, release_ev;
  logic [1:0] irq_sel;
  logic [7:0] pwrcfg_q, cputyp_q, srcsel_q, stat0_q, stat1_q, cnt_q;
  logic       smi_q;
  logic [3:0] irq_q;

  swsmi_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .blocked(blocked_o), .fire(fire),
    .restart(restart), .cnt_load(cnt_load), .irq_mode(irq_mode),
    .irq_sel(irq_sel), .pwrcfg_q(pwrcfg_q), .cputyp_q(cputyp_q),
    .srcsel_q(srcsel_q), .stat0_q(stat0_q), .stat1_q(stat1_q)
  );

  swsmi_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(run_q), .clr(cnt_load || restart),
    .step(step)
  );

  swsmi_blocktimer u_tmr (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cfg_wdata),
    .restart(restart), .step(step), .fire(fire), .cnt_q(cnt_q),
    .run_q(run_q), .blocked_q(blocked_o), .release_ev(release_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi_q <= 1'b0;
      irq_q <= '0;
    end else begin
      irq_q <= (fire && irq_mode) ? f_irq_onehot(irq_sel) : 4'b0000;
      if (fire && !irq_mode) smi_q <= 1'b1;
      else if (smi_ack)      smi_q <= 1'b0;
    end
  end

  assign smi_o   = smi_q;
  assign irq_req = irq_q;

  always_comb begin
    unique case (cfg_addr)
      A_PWRCFG: cfg_rdata = pwrcfg_q;
      A_CPUTYP: cfg_rdata = cputyp_q;
      A_SRCSEL: cfg_rdata = srcsel_q;
      A_COUNT:  cfg_rdata = cnt_q;
      A_TRIG:   cfg_rdata = {7'b0, run_q};
      A_STAT0:  cfg_rdata = stat0_q;
      A_STAT1:  cfg_rdata = stat1_q;
      default:  cfg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/swsmi_chk.sv
module swsmi_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic       smi_ack,
  input logic       smi_o,
  input logic [3:0] irq_req,
  input logic       blocked_o,
  input logic [7:0] cnt_q,
  input logic       run_q,
  input logic       step,
  input logic       cnt_load,
  input logic       release_ev
);
  p_block_from_trigger_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blocked_o) |-> $past(cfg_we && cfg_addr == 3'd4 && cfg_wdata[0]));

  p_line_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_o && !smi_ack) |=> smi_o);

  p_irq_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_req));

  p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != 4'b0) |=> (irq_req == 4'b0));

  p_step_only_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> run_q);

  p_step_decrements_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_load && !release_ev) |=> (cnt_q == $past(cnt_q) - 8'd1));

  p_release_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blocked_o) |-> (cnt_q == 8'd0 && !run_q));

  p_idle_needs_small_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt_q >= 8'd2));
endmodule

bind swsmi_gen swsmi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .smi_ack(smi_ack), .smi_o(smi_o),
  .irq_req(irq_req), .blocked_o(blocked_o), .cnt_q(cnt_q), .run_q(run_q),
  .step(step), .cnt_load(cnt_load), .release_ev(release_ev)
);

// File: tb/tb_swsmi_gen.sv
`timescale 1ns/1ps
module tb_swsmi_gen;
  localparam int DIV = 2 * 35;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] cfg_rdata;
  logic       smi_ack = 1'b0;
  logic       smi_o;
  logic [3:0] irq_req;
  logic       blocked_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  swsmi_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smi_ack(smi_ack),
    .smi_o(smi_o), .irq_req(irq_req), .blocked_o(blocked_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); smi_ack = 1'b1;
    @(negedge clk); smi_ack = 1'b0;
  endtask

  task automatic unblock();
    wr(3'd3, 8'd2);
    wait_cyc(DIV);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R10 reg", d, 0);
    end
    chk("R10 smi", smi_o, 0);
    chk("R10 irq", irq_req, 0);
    chk("R10 blocked", blocked_o, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R9 mask ff", d, 8'h9F);
    wr(3'd1, 8'h60); rd(3'd1, d); chk("R9 mask 60", d, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_gate_line();
    logic [7:0] d;
    wr(3'd4, 8'h01);
    rd(3'd5, d);
    chk("R1 no enable blocked", blocked_o, 0);
    chk("R1 no enable stat", d, 0);
    chk("R1 no enable smi", smi_o, 0);
    wr(3'd0, 8'h80);
    wr(3'd4, 8'h01);
    chk("R1 no select blocked", blocked_o, 0);
    chk("R1 no select smi", smi_o, 0);
    wr(3'd2, 8'h10);
    wr(3'd4, 8'h01);
    rd(3'd5, d);
    chk("R4 blocked set", blocked_o, 1);
    chk("R4 stat0 bit4", d, 8'h10);
    chk("R2 line set", smi_o, 1);
    chk("R2 no irq", irq_req, 0);
    wait_cyc(6);
    chk("R2 line held", smi_o, 1);
    wr(3'd5, 8'h10);
    rd(3'd5, d); chk("R5 stat0 cleared", d, 0);
    wr(3'd4, 8'h01);
    rd(3'd5, d); chk("R1 blocked ignores trigger", d, 0);
    ack();
    chk("R2 line cleared by ack", smi_o, 0);
    unblock();
    chk("R7 unblocked", blocked_o, 0);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(3'd4, 8'h01);
    ack();
    wr(3'd5, 8'hEF);
    rd(3'd5, d); chk("R5 zero bit kept", d, 8'h10);
    wr(3'd5, 8'h10);
    rd(3'd5, d); chk("R5 one bit cleared", d, 8'h00);
    wr(3'd6, 8'hFF);
    rd(3'd6, d); chk("R5 stat1 stays clear", d, 8'h00);
    unblock();
  endtask

  task automatic t_irq();
    wr(3'd0, 8'h90);
    for (int s = 0; s < 4; s++) begin
      wr(3'd1, 8'(s));
      wr(3'd4, 8'h01);
      chk("R3 irq onehot", irq_req, 1 << s);
      chk("R3 smi low", smi_o, 0);
      wait_cyc(1);
      chk("R3 pulse ends", irq_req, 0);
      unblock();
    end
    wr(3'd0, 8'h80);
  endtask

  task automatic t_countdown();
    logic [7:0] d;
    wr(3'd4, 8'h01);
    ack();
    wr(3'd3, 8'd5);
    rd(3'd4, d); chk("R6 running flag", d, 1);
    wait_cyc(DIV - 1);
    rd(3'd3, d); chk("R7 before first step", d, 5);
    wait_cyc(1);
    rd(3'd3, d); chk("R7 first step", d, 4);
    wait_cyc(2 * DIV);
    rd(3'd3, d); chk("R7 third step", d, 2);
    chk("R7 still blocked", blocked_o, 1);
    wait_cyc(DIV - 1);
    chk("R7 one cycle early", blocked_o, 1);
    wait_cyc(1);
    rd(3'd3, d);
    chk("R7 released", blocked_o, 0);
    chk("R7 count zero", d, 0);
    rd(3'd4, d); chk("R7 stopped", d, 0);
  endtask

  task automatic t_small_restart();
    logic [7:0] d;
    wr(3'd4, 8'h01);
    ack();
    wr(3'd3, 8'd1);
    wait_cyc(3 * DIV);
    rd(3'd3, d);
    chk("R6 load one blocked", blocked_o, 1);
    chk("R6 load one count", d, 1);
    rd(3'd4, d); chk("R6 load one idle", d, 0);
    wr(3'd4, 8'h02);
    rd(3'd4, d); chk("R8 restart below two idle", d, 0);
    wr(3'd3, 8'd0);
    wait_cyc(DIV + 5);
    chk("R6 load zero blocked", blocked_o, 1);
    wr(3'd3, 8'd3);
    wait_cyc(30);
    wr(3'd4, 8'h02);
    rd(3'd3, d); chk("R8 count not reloaded", d, 3);
    wait_cyc(2 * DIV - 1);
    chk("R8 restarted timing early", blocked_o, 1);
    wait_cyc(1);
    chk("R8 restarted timing release", blocked_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_gate_line();
    t_w1c();
    t_irq();
    t_countdown();
    t_small_restart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule